// File: doc/BRIEF.md
# Two-Port Ownership Token Arbiter

This block holds a small bank of single-bit ownership tokens that two ports, named left and right, share. A port claims a token to mark a shared resource as busy. It reads the token back to learn whether the claim succeeded, and it hands the token back when it has finished. A token never has two holders at once. When both ports contend, the result is decided at a clock edge with a fixed rule that favours the left port.

A port that asks for a token the other port already holds is refused, and the readback shows the refusal. The refused request is not lost. It waits in the token, and the token passes to the waiting port at the moment the holder gives it up, without a second request. Every port has its own select, write strobe, token index and data bit. The behaviour is modelled as synchronous logic on a single clock.

Top module: `dual_sem_arbiter`

## Requirements
- R1: No token is ever held by both ports at the same time.
- R2: There are NUM_SEM (default 8) independent tokens, chosen by an index of IDX_W (default 3) bits. An operation on one token leaves every other token unchanged.
- R3: A write happens when sel and wr are both 1. A data bit of 0 is a claim and a data bit of 1 is a give-back. The result shows on the readback from the cycle after the clock edge.
- R4: While sel is 1, rdata is 0 if the reading port holds the indexed token and 1 if it does not. While sel is 0, rdata is 1.
- R5: A claim on a free token makes the claiming port its holder.
- R6: A claim on a token held by the other port is refused. The holder keeps the token and the claimant reads 1.
- R7: When the holder gives back a token that the other port has a refused claim waiting on, the waiting port becomes the holder after that same edge.
- R8: When both ports claim the same free token in one cycle, the left port gets it and the right claim waits. The right port gets the token when the left port gives it back.
- R9: A give-back from a port that does not hold the token changes no token state.
- R10: After reset every token is free and no claim is waiting.
- R11: A write strobe with sel at 0 has no effect on any token.
- R12: A claim by the current holder leaves the token with that holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port token select |
| l_wr | input | 1 | Left port write strobe |
| l_idx | input | IDX_W | Left port token index |
| l_wdata | input | 1 | Left port data bit (0 claim, 1 give-back) |
| l_rdata | output | 1 | Left port readback (0 means held by left) |
| r_sel | input | 1 | Right port token select |
| r_wr | input | 1 | Right port write strobe |
| r_idx | input | IDX_W | Right port token index |
| r_wdata | input | 1 | Right port data bit (0 claim, 1 give-back) |
| r_rdata | output | 1 | Right port readback (0 means held by right) |

## Verification
The claim path is tried four ways: on a free token, against a token the other port holds, by both ports on the same token in one cycle, and by both ports on different tokens in one cycle. These cases separate a plain grant from a refusal, from left priority and from independence between tokens. Give-back is tried by the holder with a claim waiting, by the holder with no claim waiting, and by a port that does not hold the token. These cases separate automatic hand-over from freeing and from a wrongly accepted give-back. Strobes sent with select low, and repeated claims by the holder, show that neither disturbs the stored state.

// File: rtl/sem_arb_pkg.sv
package sem_arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } tok_state_t;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wdata,
    output logic [NUM_SEM-1:0] claim,
    output logic [NUM_SEM-1:0] giveback
);
    logic strobe;
    assign strobe = sel & wr;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        logic hit;
        assign hit         = strobe && (idx == IDX_W'(g));
        assign claim[g]    = hit & ~wdata;
        assign giveback[g] = hit &  wdata;
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_claim,
    input  logic l_give,
    input  logic r_claim,
    input  logic r_give,
    output logic l_own,
    output logic r_own
);
    tok_state_t st_d, st_q;
    owner_e     mid_own;
    logic       l_want, r_want;

    always_comb begin
        st_d    = st_q;
        mid_own = st_q.owner;
        if (l_give && mid_own == OWN_LEFT)  mid_own = OWN_NONE;
        if (r_give && mid_own == OWN_RIGHT) mid_own = OWN_NONE;
        l_want = l_claim | st_q.wait_l;
        r_want = r_claim | st_q.wait_r;
        if (mid_own == OWN_NONE) begin
            if (l_want) begin
                mid_own     = OWN_LEFT;
                st_d.wait_l = 1'b0;
                if (r_claim) st_d.wait_r = 1'b1;
            end else if (r_want) begin
                mid_own     = OWN_RIGHT;
                st_d.wait_r = 1'b0;
            end
        end else begin
            if (mid_own == OWN_LEFT  && r_claim) st_d.wait_r = 1'b1;
            if (mid_own == OWN_RIGHT && l_claim) st_d.wait_l = 1'b1;
        end
        st_d.owner = mid_own;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};
        else        st_q <= st_d;
    end

    assign l_own = (st_q.owner == OWN_LEFT);
    assign r_own = (st_q.owner == OWN_RIGHT);
endmodule

// File: rtl/dual_sem_arbiter.sv
module dual_sem_arbiter #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel,
    input  logic             l_wr,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wdata,
    output logic             l_rdata,
    input  logic             r_sel,
    input  logic             r_wr,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wdata,
    output logic             r_rdata
);
    logic [NUM_SEM-1:0] l_claim_v, l_give_v, r_claim_v, r_give_v;
    logic [NUM_SEM-1:0] l_own_v, r_own_v;

    sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .idx(l_idx), .wdata(l_wdata),
        .claim(l_claim_v), .giveback(l_give_v)
    );

    sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .idx(r_idx), .wdata(r_wdata),
        .claim(r_claim_v), .giveback(r_give_v)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_tok
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_claim(l_claim_v[g]), .l_give(l_give_v[g]),
            .r_claim(r_claim_v[g]), .r_give(r_give_v[g]),
            .l_own(l_own_v[g]), .r_own(r_own_v[g])
        );
    end

    assign l_rdata = l_sel ? ~l_own_v[l_idx] : 1'b1;
    assign r_rdata = r_sel ? ~r_own_v[r_idx] : 1'b1;
endmodule

// File: rtl/sem_arbiter_chk.sv
module sem_arbiter_chk #(
    parameter int NUM_SEM = 8,
    parameter int IDX_W   = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel,
    input logic               l_wr,
    input logic [IDX_W-1:0]   l_idx,
    input logic               l_wdata,
    input logic               r_sel,
    input logic               r_wr,
    input logic [IDX_W-1:0]   r_idx,
    input logic               r_wdata,
    input logic [NUM_SEM-1:0] l_own,
    input logic [NUM_SEM-1:0] r_own
);
    logic l_str, r_str;
    assign l_str = l_sel & l_wr;
    assign r_str = r_sel & r_wr;

    AST_NO_DOUBLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0); // R1

    AST_FREE_CLAIM_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (l_str && !l_wdata && !l_own[l_idx] && !r_own[l_idx])
        |=> l_own[$past(l_idx)]); // R5

    AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_str && !r_wdata && l_own[r_idx] && !(l_str && l_wdata && l_idx == r_idx))
        |=> (l_own[$past(r_idx)] && !r_own[$past(r_idx)])); // R6

    AST_BAD_GIVEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (l_str && l_wdata && !l_own[l_idx] && !r_str)
        |=> ($stable(l_own) && $stable(r_own))); // R9

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_str && !r_str) |=> ($stable(l_own) && $stable(r_own))); // R11
endmodule

bind dual_sem_arbiter sem_arbiter_chk #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wdata(l_wdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wdata(r_wdata),
    .l_own(l_own_v), .r_own(r_own_v)
);

// File: tb/dual_sem_arbiter_bench.sv
module dual_sem_arbiter_bench;
    localparam int NS = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_wr = 0, l_wdata = 1, r_sel = 0, r_wr = 0, r_wdata = 1;
    logic [IW-1:0] l_idx = '0, r_idx = '0;
    logic l_rdata, r_rdata;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_sem_arbiter #(.NUM_SEM(NS)) u_dual_sem_arbiter (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one write cycle on either or both ports; drive at negedge, edge, back to negedge
    task automatic wr_both(input logic lw, input logic [IW-1:0] li, input logic ld,
                           input logic rw, input logic [IW-1:0] ri, input logic rd);
        l_sel = lw; l_wr = lw; l_idx = li; l_wdata = ld;
        r_sel = rw; r_wr = rw; r_idx = ri; r_wdata = rd;
        @(posedge clk); @(negedge clk);
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    endtask

    // read both ports in the low phase; readback is combinational from stored state
    task automatic rd(input logic [IW-1:0] li, input logic [IW-1:0] ri,
                      input logic el, input logic er, input string req);
        l_sel = 1; l_wr = 0; l_idx = li;
        r_sel = 1; r_wr = 0; r_idx = ri;
        #1;
        chk({req, " left"}, l_rdata, el);
        chk({req, " right"}, r_rdata, er);
        l_sel = 0; r_sel = 0;
        #1;
    endtask

    task automatic t_reset;
        for (int i = 0; i < NS; i++) rd(IW'(i), IW'(i), 1'b1, 1'b1, "R10 reset free");
        #1;
        chk("R4 sel low left", l_rdata, 1'b1);
        chk("R4 sel low right", r_rdata, 1'b1);
    endtask

    task automatic t_claim_refuse;
        wr_both(1, 3'd2, 0, 0, 3'd0, 1);
        rd(3'd2, 3'd2, 1'b0, 1'b1, "R5 R3 free claim");
        wr_both(0, 3'd0, 1, 1, 3'd2, 0);
        rd(3'd2, 3'd2, 1'b0, 1'b1, "R6 refused claim");
        checks++;
        if (l_rdata === 1'b0 && r_rdata === 1'b0) begin
            errors++;
            $display("FAIL R1 both own actual=00 expected=not both 0");
        end
    endtask

    task automatic t_handover;
        wr_both(1, 3'd2, 1, 0, 3'd0, 1);
        rd(3'd2, 3'd2, 1'b1, 1'b0, "R7 waiting claim granted");
    endtask

    task automatic t_bad_giveback;
        wr_both(1, 3'd2, 1, 0, 3'd0, 1);
        rd(3'd2, 3'd2, 1'b1, 1'b0, "R9 non-holder giveback");
        wr_both(0, 3'd0, 1, 1, 3'd2, 1);
        rd(3'd2, 3'd2, 1'b1, 1'b1, "R3 holder giveback frees");
    endtask

    task automatic t_same_cycle;
        wr_both(1, 3'd5, 0, 1, 3'd5, 0);
        rd(3'd5, 3'd5, 1'b0, 1'b1, "R8 left priority");
        wr_both(1, 3'd5, 1, 0, 3'd0, 1);
        rd(3'd5, 3'd5, 1'b1, 1'b0, "R8 queued right granted");
    endtask

    task automatic t_independent;
        wr_both(1, 3'd0, 0, 1, 3'd7, 0);
        rd(3'd0, 3'd7, 1'b0, 1'b0, "R2 both granted distinct");
        rd(3'd7, 3'd0, 1'b1, 1'b1, "R2 crossed view");
        rd(3'd3, 3'd3, 1'b1, 1'b1, "R2 untouched token");
        rd(3'd5, 3'd5, 1'b1, 1'b0, "R2 earlier token kept");
    endtask

    task automatic t_sel_low;
        l_sel = 0; l_wr = 1; l_idx = 3'd4; l_wdata = 0;
        r_sel = 0; r_wr = 1; r_idx = 3'd4; r_wdata = 0;
        @(posedge clk); @(negedge clk);
        l_wr = 0; r_wr = 0;
        rd(3'd4, 3'd4, 1'b1, 1'b1, "R11 strobe without sel");
        l_sel = 0; l_wr = 1; l_idx = 3'd0; l_wdata = 1;
        @(posedge clk); @(negedge clk);
        l_wr = 0;
        rd(3'd0, 3'd7, 1'b0, 1'b0, "R11 giveback without sel");
    endtask

    task automatic t_reclaim;
        wr_both(1, 3'd0, 0, 0, 3'd0, 1);
        rd(3'd0, 3'd0, 1'b0, 1'b1, "R12 holder reclaims");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_claim_refuse();
        t_handover();
        t_bad_giveback();
        t_same_cycle();
        t_independent();
        t_sel_low();
        t_reclaim();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule